// File: doc/BRIEF.md
# Life-Cycle Transition Sequencer

This block steps a chip through one requested change of its life-cycle state. After reset it settles in an idle state. A transition request starts a fixed chain of steps: clock switch-over, counter increment, counter programming, transition validity check, token hashing, a flash erase step, two token comparisons, and programming of the new state. Each step raises a request towards a stub interface and waits for an acknowledge that may carry an error. Most steps leave early to a locked post-transition state when they get an error. The final programming step also ends in that locked state.

Two redundant escalation inputs override everything else. Either one sends the controller into a terminal escalation state from any state. The state register holds sparse 12-bit codewords that are at least three bit flips apart. Any value that is not a legal codeword is caught and sent to a trap state, and a sticky flag records it. Sticky flags also record which step failed. Only reset clears them.

Top module: `lcx_seq_top`

## Requirements
- R1: While `rstN` is low, `stepId` reads 0 (reset state), `stepReq` is 0 and `errFlags` is 0. The first clock edge after reset is released moves the controller to idle (`stepId` 1).
- R2: In idle, `scrapReq` moves to the scrap state (`stepId` 12) and takes priority over `transReq`. `transReq` alone moves to clock switch-over (`stepId` 2). With neither, the controller stays idle.
- R3: `stepReq` is 1 exactly in the step states, `stepId` 2 to 10. In each of those states except 9, the controller stays put while `stepAck` is 0.
- R4: An acknowledge without error advances the step chain in this order: 2 clock switch, 3 counter increment, 4 counter program, 5 transition check, 6 token hash, 7 flash erase, 8 token compare 0, 9 token compare 1, 10 state program, 11 post-transition.
- R5: An acknowledge with `stepErr` in states 3, 4, 5, 6, 8 or 10 moves to post-transition (11) and sets one flag bit: bit 0 for state 3, bit 1 for 4, bit 2 for 5, bit 3 for 6, bit 4 for 8, bit 6 for 10. `stepErr` has no effect in states 2 and 7.
- R6: State 9 lasts exactly one cycle. If `stepAck` is 1 and `stepErr` is 0 it goes to 10. Otherwise it goes to 11 and sets flag bit 5.
- R7: If `escA` or `escB` is 1, the next state is escalation (13) from any state. This overrides every other input, and no step-failure flag is set in that cycle.
- R8: Post-transition (11) and scrap (12) hold until reset unless escalation occurs. Escalation (13) holds until reset. The trap state (14) holds until escalation.
- R9: When the state register holds a value that is not a legal codeword, `stepId` reads 15 and flag bit 7 is set at the next edge. The controller enters the trap state (14) at that edge.
- R10: Every bit of `errFlags`, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| escA | input | 1 | Escalation input, first copy |
| escB | input | 1 | Escalation input, second copy |
| scrapReq | input | 1 | Scrap request, sampled in idle |
| transReq | input | 1 | Transition start request, sampled in idle |
| stepAck | input | 1 | Acknowledge for the current step |
| stepErr | input | 1 | Error qualifier for `stepAck` |
| stepReq | output | 1 | Current step awaits an acknowledge |
| stepId | output | 4 | Current state index, 15 for an illegal code |
| errFlags | output | 8 | Sticky step-failure flags, bit 7 illegal code |

## Verification
The bench targets escalation arriving in every state, including the terminal and trap states. A design that let a step or a terminal state win would stay put or set a failure flag. It sends errors to the clock switch and flash erase steps, where a wrong design would leave early. It holds back the acknowledge in the single-cycle token compare, where a wrong design would wait. It also makes idle see scrap and transition requests together, which shows whether the priority is wrong. Finally, it plants an illegal codeword in the state register. A design without the trap would either stay in that value or fall into a legal state with no flag raised.

// File: rtl/lcx_pkg.sv
package lcx_pkg;
  parameter int unsigned IDX_W  = 4;
  parameter int unsigned COPIES = 3;
  localparam int unsigned STATE_W    = IDX_W * COPIES;
  localparam int unsigned NUM_STATES = 15;
  localparam int unsigned FAIL_W     = 7;
  localparam int unsigned FLAG_W     = FAIL_W + 1;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  typedef enum logic [IDX_W-1:0] {
    S_RESET = 0, S_IDLE, S_CLKSW, S_CNTINC, S_CNTPRG, S_TRCHK, S_TKHASH,
    S_FLERASE, S_TKCMP0, S_TKCMP1, S_TRPRG, S_POST, S_SCRAP, S_ESC, S_INVAL
  } lcxIdx_e;

  typedef struct packed {
    logic [FAIL_W-1:0] failSet;
    logic              illegalSet;
  } lcxStrobe_t;

  // Each copy of the index is XORed with its own mask, so two different
  // indices differ in every copy: minimum distance equals COPIES.
  function automatic logic [STATE_W-1:0] encodeState(logic [IDX_W-1:0] idx);
    logic [STATE_W-1:0] code;
    for (int k = 0; k < COPIES; k++) begin
      code[k*IDX_W +: IDX_W] = idx ^ IDX_W'(k * 5);
    end
    return code;
  endfunction

  function automatic logic [FAIL_W-1:0] failBit(lcxIdx_e s);
    logic [FAIL_W-1:0] b;
    b = '0;
    case (s)
      S_CNTINC: b[0] = 1'b1;
      S_CNTPRG: b[1] = 1'b1;
      S_TRCHK:  b[2] = 1'b1;
      S_TKHASH: b[3] = 1'b1;
      S_TKCMP0: b[4] = 1'b1;
      S_TKCMP1: b[5] = 1'b1;
      S_TRPRG:  b[6] = 1'b1;
      default:  b = '0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcx_ctrl.sv
module lcx_ctrl
  import lcx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              escA,
  input  logic              escB,
  input  logic              scrapReq,
  input  logic              transReq,
  input  logic              stepAck,
  input  logic              stepErr,
  output logic              stepReq,
  output logic [IDX_W-1:0]  curIdx,
  output lcxStrobe_t        strobe
);
  logic [STATE_W-1:0]    stateQ, stateD;
  logic [NUM_STATES-1:0] hit;
  logic                  legal, escAny, failTake;
  lcxIdx_e               curSt, nextSt;

  // comparator bank against every legal codeword
  for (genvar g = 0; g < NUM_STATES; g++) begin : gHit
    assign hit[g] = (stateQ == encodeState(IDX_W'(g)));
  end

  assign legal  = |hit;
  assign escAny = escA | escB;

  always_comb begin
    curSt = S_INVAL;
    for (int i = 0; i < NUM_STATES; i++) begin
      if (hit[i]) curSt = lcxIdx_e'(IDX_W'(i));
    end
  end

  always_comb begin
    nextSt   = curSt;
    failTake = 1'b0;
    case (curSt)
      S_RESET: nextSt = S_IDLE;
      S_IDLE: begin
        if (scrapReq)      nextSt = S_SCRAP;
        else if (transReq) nextSt = S_CLKSW;
      end
      S_CLKSW, S_FLERASE: begin
        if (stepAck) nextSt = lcxIdx_e'(curSt + 1'b1);
      end
      S_CNTINC, S_CNTPRG, S_TRCHK, S_TKHASH, S_TKCMP0, S_TRPRG: begin
        if (stepAck) begin
          if (stepErr) begin
            nextSt   = S_POST;
            failTake = 1'b1;
          end else begin
            nextSt = lcxIdx_e'(curSt + 1'b1);
          end
        end
      end
      S_TKCMP1: begin
        if (stepAck && !stepErr) begin
          nextSt = S_TRPRG;
        end else begin
          nextSt   = S_POST;
          failTake = 1'b1;
        end
      end
      default: nextSt = curSt;
    endcase
    if (!legal)  nextSt = S_INVAL;
    if (escAny)  nextSt = S_ESC;
  end

  assign stateD = encodeState(nextSt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= encodeState(S_RESET);
    else       stateQ <= stateD;
  end

  assign strobe.failSet    = (failTake && legal && !escAny) ? failBit(curSt) : '0;
  assign strobe.illegalSet = !legal;
  assign stepReq = legal && (curSt >= S_CLKSW) && (curSt <= S_TRPRG);
  assign curIdx  = legal ? curSt : IDX_NONE;

  AST_IDLE_SCRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == encodeState(S_IDLE) && scrapReq && !escAny)
      |=> (stateQ == encodeState(S_SCRAP))); // R2
  AST_STEP_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stepReq && !stepAck && !escAny && stateQ != encodeState(S_TKCMP1))
      |=> $stable(stateQ)); // R3
  AST_TKCMP1_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == encodeState(S_TKCMP1)) |=> (stateQ != encodeState(S_TKCMP1))); // R6
  AST_ESC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    escAny |=> (stateQ == encodeState(S_ESC))); // R7
  AST_POST_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == encodeState(S_POST) && !escAny)
      |=> (stateQ == encodeState(S_POST))); // R8
  AST_ILLEGAL_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!legal && !escAny) |=> (stateQ == encodeState(S_INVAL))); // R9
endmodule

// File: rtl/lcx_dpath.sv
module lcx_dpath
  import lcx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lcxStrobe_t        strobe,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flagsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsQ | {strobe.illegalSet, strobe.failSet};
  end

  assign flags = flagsQ;

  AST_FAIL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.failSet)); // R5
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagsQ != '0) |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ))); // R10
endmodule

// File: rtl/lcx_seq_top.sv
module lcx_seq_top
  import lcx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              escA,
  input  logic              escB,
  input  logic              scrapReq,
  input  logic              transReq,
  input  logic              stepAck,
  input  logic              stepErr,
  output logic              stepReq,
  output logic [IDX_W-1:0]  stepId,
  output logic [FLAG_W-1:0] errFlags
);
  lcxStrobe_t strobe;

  lcx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .escA(escA), .escB(escB),
    .scrapReq(scrapReq), .transReq(transReq),
    .stepAck(stepAck), .stepErr(stepErr),
    .stepReq(stepReq), .curIdx(stepId), .strobe(strobe)
  );

  lcx_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flags(errFlags)
  );
endmodule

// File: tb/sim_lcx_seq_top.sv
`timescale 1ns/1ps
module sim_lcx_seq_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic escA = 0, escB = 0, scrapReq = 0, transReq = 0, stepAck = 0, stepErr = 0;
  logic       stepReq;
  logic [3:0] stepId;
  logic [7:0] errFlags;
  int checks = 0;
  int fails = 0;
  logic [3:0] mIdx;
  logic [7:0] mFlags;

  always #4 clk = ~clk;

  lcx_seq_top u0 (
    .clk(clk), .rstN(rstN), .escA(escA), .escB(escB), .scrapReq(scrapReq),
    .transReq(transReq), .stepAck(stepAck), .stepErr(stepErr),
    .stepReq(stepReq), .stepId(stepId), .errFlags(errFlags)
  );

  function automatic logic [3:0] mNext(logic [3:0] s, bit ea, bit eb, bit sc,
                                       bit tr, bit ak, bit er);
    if (ea || eb) return 4'd13;
    case (s)
      4'd0:  return 4'd1;
      4'd1:  return sc ? 4'd12 : (tr ? 4'd2 : 4'd1);
      4'd2:  return ak ? 4'd3 : 4'd2;
      4'd3:  return ak ? (er ? 4'd11 : 4'd4) : 4'd3;
      4'd4:  return ak ? (er ? 4'd11 : 4'd5) : 4'd4;
      4'd5:  return ak ? (er ? 4'd11 : 4'd6) : 4'd5;
      4'd6:  return ak ? (er ? 4'd11 : 4'd7) : 4'd6;
      4'd7:  return ak ? 4'd8 : 4'd7;
      4'd8:  return ak ? (er ? 4'd11 : 4'd9) : 4'd8;
      4'd9:  return (ak && !er) ? 4'd10 : 4'd11;
      4'd10: return ak ? 4'd11 : 4'd10;
      default: return s;
    endcase
  endfunction

  function automatic logic [7:0] mFail(logic [3:0] s, bit ea, bit eb, bit ak, bit er);
    if (ea || eb) return 8'h00;
    case (s)
      4'd3:  return (ak && er) ? 8'h01 : 8'h00;
      4'd4:  return (ak && er) ? 8'h02 : 8'h00;
      4'd5:  return (ak && er) ? 8'h04 : 8'h00;
      4'd6:  return (ak && er) ? 8'h08 : 8'h00;
      4'd8:  return (ak && er) ? 8'h10 : 8'h00;
      4'd9:  return (ak && !er) ? 8'h00 : 8'h20;
      4'd10: return (ak && er) ? 8'h40 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagFor(logic [3:0] s, bit ea, bit eb, bit ak, bit er);
    if (ea || eb) return "R7";
    case (s)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd9: return "R6";
      4'd11, 4'd12, 4'd13, 4'd14: return "R8";
      default: return !ak ? "R3" : (er ? "R5" : "R4");
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "stepId", 32'(stepId), 32'(mIdx));
    chk("R3", "stepReq", 32'(stepReq), 32'((mIdx >= 4'd2) && (mIdx <= 4'd10)));
    chk("R10", "errFlags", 32'(errFlags), 32'(mFlags));
  endtask

  // called at a negedge: drive, let one edge pass, compare
  task automatic step(bit ea, bit eb, bit sc, bit tr, bit ak, bit er);
    logic [3:0] nx;
    string tag;
    escA = ea; escB = eb; scrapReq = sc; transReq = tr; stepAck = ak; stepErr = er;
    nx  = mNext(mIdx, ea, eb, sc, tr, ak, er);
    tag = tagFor(mIdx, ea, eb, ak, er);
    mFlags = mFlags | mFail(mIdx, ea, eb, ak, er);
    @(negedge clk);
    mIdx = nx;
    checkAll(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {escA, escB, scrapReq, transReq, stepAck, stepErr} = '0;
    @(negedge clk); @(negedge clk);
    chk("R1", "reset stepId", 32'(stepId), 32'd0);
    chk("R1", "reset stepReq", 32'(stepReq), 32'd0);
    chk("R1", "reset errFlags", 32'(errFlags), 32'd0);
    rstN = 1'b1;
    mIdx = 4'd0;
    mFlags = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed: full successful path, every index along the way (R11-style listing in R4)
    doReset();
    step(0, 0, 0, 0, 0, 0);                 // R1 reset -> idle
    step(0, 0, 0, 1, 0, 0);                 // R2 idle -> clock switch
    step(0, 0, 0, 0, 0, 1);                 // R3 wait, error without ack
    step(0, 0, 0, 0, 1, 1);                 // R5 error ignored in clock switch
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0); // R4 chain to compare 1
    chk("R4", "reached compare1", 32'(stepId), 32'd9);
    step(0, 0, 0, 0, 1, 0);                 // R6 -> program
    step(0, 0, 0, 0, 1, 0);                 // R4 -> post
    chk("R4", "post reached", 32'(stepId), 32'd11);
    step(0, 0, 1, 1, 1, 1);                 // R8 terminal
    step(0, 1, 0, 0, 0, 0);                 // R7 escB from post
    step(0, 0, 0, 0, 0, 0);                 // R8 escalate holds

    // directed: scrap wins over transition request, then escA
    doReset();
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0);                 // R2
    chk("R2", "scrap priority", 32'(stepId), 32'd12);
    step(1, 0, 0, 0, 0, 0);                 // R7

    // directed: compare 1 without ack fails, flag bit 5
    doReset();
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);                 // R6 no ack -> post, bit 5
    chk("R6", "compare1 fail flag", 32'(errFlags), 32'h20);

    // directed: illegal codeword planted in the state register
    doReset();
    step(0, 0, 0, 0, 0, 0);
    force u0.uCtrl.stateQ = 12'h000;
    #1;
    chk("R9", "illegal shown", 32'(stepId), 32'd15);
    release u0.uCtrl.stateQ;
    @(negedge clk);
    mIdx = 4'd14;
    mFlags = 8'h80;
    checkAll("R9");
    step(0, 0, 0, 1, 1, 1);                 // R8 trap holds
    step(1, 1, 0, 0, 0, 0);                 // R7 trap -> escalate

    // random episodes
    for (int ep = 0; ep < 400; ep++) begin
      doReset();
      for (int c = 0; c < 40; c++) begin
        bit ea, eb, sc, tr, ak, er;
        ea = ($urandom % 100) == 0;
        eb = ($urandom % 100) == 0;
        sc = ($urandom % 20) == 0;
        tr = ($urandom % 3) == 0;
        ak = ($urandom % 4) != 0;
        er = ($urandom % 12) == 0;
        step(ea, eb, sc, tr, ak, er);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule